// File: doc/BRIEF.md
# Power-Supply Control Register Target on a Two-Wire Bus

This block is the serial control port of a multi-output power-supply chip. It listens on a two-wire serial bus (clock and open-drain data), answers the fixed 7-bit target address, and holds three 8-bit control registers. These are the output enables, the voltage selections, and the detector thresholds with the flag mode. The register contents go straight to the output-control logic. A one-cycle write strobe and the register index mark every committed write.

A write is START, address with R/W = 0, one sub-address byte, one data byte and STOP. There is exactly one data byte per transfer and no address increment. A read is START, address with R/W = 1, then two bytes of a 16-bit status word, high byte first, then STOP. A read has no sub-address phase. The status word is taken from live detector inputs and from the voltage-selection register at the moment the address is acknowledged. Both bus lines pass through a two-flop synchroniser, and every bus event is judged on the system clock. The block has no data stream at its edge, so its ports are plain control and status pins with no valid/ready handshake.

Top module: `pmic_i2c_target`

## Requirements
- R1: After reset, all three registers read 00h and the data-line pull-down (`sda_oe`) is released.
- R2: The block answers address 0001000 (bits sent MSB first, followed by R/W, where 1 = read). It acknowledges by pulling the data line low for the ninth clock of the address byte, and `sda_oe` only changes while the synchronised clock is low.
- R3: When the address does not match, the block does not acknowledge and keeps `sda_oe` released for the rest of the transfer, until the next START.
- R4: A write of sub-address 00h, 01h or 02h followed by one data byte stores that byte in `reg_enable`, `reg_vsel` or `reg_detcfg`. One `wr_strobe` pulse marks the write, with `wr_index` equal to the sub-address. The registers change only on such a strobe.
- R5: Only one data byte is accepted per write. A second data byte is not acknowledged and changes no register.
- R6: A data byte sent to sub-address 03h or above is acknowledged, produces no strobe, and changes no register.
- R7: A read returns the status word MSB first as two bytes. Bits 15:9 are `reg_vsel[7:1]`. Bit 8 is `v6_feeds_core`. Bits 7:2 are `det_flags[5:0]`, where `det_flags[5]` is the ACC-low flag and `det_flags[0]` is the overcurrent flag. Bits 1:0 are 0.
- R8: The status word is captured when the address byte is acknowledged. Later changes on `v6_feeds_core` or `det_flags` do not alter the bytes of that read.
- R9: A STOP or a repeated START in the middle of a byte abandons the transfer with no register update. A START is then accepted at once.
- R10: When the controller does not acknowledge the first read byte, the block releases the data line for the rest of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain) |
| v6_feeds_core | input | 1 | 1 when the core regulator runs from the 6 V input |
| det_flags | input | 6 | ACC-low, UV, OV, OVP, 6 V-lost, overcurrent (bit 5 down to bit 0) |
| reg_enable | output | 8 | Register 00h: output enables in bits 7:2 |
| reg_vsel | output | 8 | Register 01h: voltage selections |
| reg_detcfg | output | 8 | Register 02h: detector thresholds and flag mode |
| wr_strobe | output | 1 | One-cycle pulse on a committed register write |
| wr_index | output | 2 | Register written when `wr_strobe` is high |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, three registers and target address 0001000. It drives the bus with a 10-cycle half period. Because there are only three registers, the bench can cover every defined sub-address and a run of undefined ones, including 0FFh, within a few thousand cycles each. Because the flag field is only six bits wide, all 64 combinations of the detector flags can be read back, with the core-supply bit and the voltage field varied alongside them. This leaves room in the run for the cases that span a whole transfer: address mismatch, a second data byte, a mid-byte STOP, a mid-byte repeated START, the status snapshot and a controller NACK.

// File: rtl/pmic_i2c_pkg.sv
package pmic_i2c_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NREG    = 3;
  localparam int unsigned IDX_W   = 2;
  localparam int unsigned STAT_W  = 16;
  localparam int unsigned FLAG_W  = 6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } tgt_state_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '1;
      else if (s == 0) chain[s] <= d_in;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/bus_events.sv
module bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign ev_rise  = scl_s & ~scl_q;
  assign ev_fall  = ~scl_s & scl_q;
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/target_fsm.sv
module target_fsm
  import pmic_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic [STAT_W-1:0] status_word,
  output logic              sda_oe,
  output logic              wr_strobe,
  output logic [IDX_W-1:0]  wr_index,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tgt_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] sub;
  logic [STAT_W-1:0] rd_sh;
  logic              rw, second, mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; sub <= '0; rd_sh <= '0;
      rw <= 1'b0; second <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      wr_strobe <= 1'b0; wr_index <= '0; wr_data <= '0;
    end else begin
      wr_strobe <= 1'b0;
      if (ev_start) begin
        st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (ev_stop) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_SUB, ST_DATA: begin
            if (ev_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (ev_fall && cnt == FULL) begin
              cnt <= '0;
              case (st)
                ST_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1; rw <= sh[0]; rd_sh <= status_word;
                    st <= ST_ADDR_ACK;
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                ST_SUB: begin
                  sub <= sh; sda_oe <= 1'b1; st <= ST_SUB_ACK;
                end
                default: begin
                  sda_oe <= 1'b1; st <= ST_DATA_ACK;
                  if (sub < BYTE_W'(NREG)) begin
                    wr_strobe <= 1'b1;
                    wr_index  <= sub[IDX_W-1:0];
                    wr_data   <= sh;
                  end
                end
              endcase
            end
          end
          ST_ADDR_ACK: if (ev_fall) begin
            if (rw) begin
              st <= ST_RD; second <= 1'b0; sda_oe <= ~rd_sh[STAT_W-1];
            end else begin
              st <= ST_SUB; sda_oe <= 1'b0;
            end
          end
          ST_SUB_ACK:  if (ev_fall) begin st <= ST_DATA; sda_oe <= 1'b0; end
          ST_DATA_ACK: if (ev_fall) begin st <= ST_WAIT; sda_oe <= 1'b0; end
          ST_RD: begin
            if (ev_rise && cnt != FULL) cnt <= cnt + 1'b1;
            else if (ev_fall) begin
              rd_sh <= {rd_sh[STAT_W-2:0], 1'b0};
              if (cnt == FULL) begin
                sda_oe <= 1'b0; cnt <= '0; st <= ST_RD_ACK;
              end else begin
                sda_oe <= ~rd_sh[STAT_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (ev_rise) mack <= ~sda_s;
            else if (ev_fall) begin
              if (mack && !second) begin
                st <= ST_RD; second <= 1'b1; sda_oe <= ~rd_sh[STAT_W-1];
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import pmic_i2c_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_strobe,
  input  logic [IDX_W-1:0]       wr_index,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic [NREG*BYTE_W-1:0] regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[i*BYTE_W +: BYTE_W] <= '0;
      else if (wr_strobe && wr_index == IDX_W'(i)) regs[i*BYTE_W +: BYTE_W] <= wr_data;
    end
  end
endmodule

// File: rtl/pmic_i2c_target.sv
module pmic_i2c_target
  import pmic_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h08,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              v6_feeds_core,
  input  logic [FLAG_W-1:0] det_flags,
  output logic [BYTE_W-1:0] reg_enable,
  output logic [BYTE_W-1:0] reg_vsel,
  output logic [BYTE_W-1:0] reg_detcfg,
  output logic              wr_strobe,
  output logic [IDX_W-1:0]  wr_index
);
  logic                   scl_s, sda_s;
  logic                   ev_rise, ev_fall, ev_start, ev_stop;
  logic [BYTE_W-1:0]      wr_data;
  logic [NREG*BYTE_W-1:0] regs;
  logic [STAT_W-1:0]      status_word;

  bus_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({scl_i, sda_i}), .d_out({scl_s, sda_s})
  );

  bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop)
  );

  assign status_word = {reg_vsel[7:1], v6_feeds_core, det_flags, 2'b00};

  target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .status_word(status_word), .sda_oe(sda_oe),
    .wr_strobe(wr_strobe), .wr_index(wr_index), .wr_data(wr_data)
  );

  reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe),
    .wr_index(wr_index), .wr_data(wr_data), .regs(regs)
  );

  assign reg_enable = regs[0*BYTE_W +: BYTE_W];
  assign reg_vsel   = regs[1*BYTE_W +: BYTE_W];
  assign reg_detcfg = regs[2*BYTE_W +: BYTE_W];
endmodule

// File: rtl/pmic_i2c_target_chk.sv
module pmic_i2c_target_chk
  import pmic_i2c_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   ev_stop,
  input logic                   sda_oe,
  input logic                   wr_strobe,
  input logic [IDX_W-1:0]       wr_index,
  input logic [NREG*BYTE_W-1:0] regs
);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  // R4
  regs_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(wr_strobe));

  // R6
  strobe_index_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_index < IDX_W'(NREG)));

  // R2
  oe_moves_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R9
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);
endmodule

bind pmic_i2c_target pmic_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .ev_stop(ev_stop), .sda_oe(sda_oe),
  .wr_strobe(wr_strobe), .wr_index(wr_index), .regs(regs)
);

// File: tb/sim_pmic_i2c_target.sv
module sim_pmic_i2c_target;
  localparam int H = 10;
  localparam logic [6:0] ADR = 7'h08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, v6 = 1'b0, wr_strobe;
  logic [5:0] flags = '0;
  logic [7:0] r_en, r_vs, r_dc;
  logic [1:0] wr_index;
  wire sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0, strobes = 0;
  logic oe_seen = 1'b0;
  logic [7:0] exp_r [3];

  always #4 clk = ~clk;

  pmic_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .v6_feeds_core(v6), .det_flags(flags), .reg_enable(r_en), .reg_vsel(r_vs),
    .reg_detcfg(r_dc), .wr_strobe(wr_strobe), .wr_index(wr_index)
  );

  always @(posedge clk) begin
    if (wr_strobe) strobes++;
    if (sda_oe) oe_seen <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waith(); repeat (H) @(negedge clk); endtask
  task automatic b_start(); sda_m = 1; waith(); scl_m = 1; waith(); sda_m = 0; waith(); scl_m = 0; waith(); endtask
  task automatic b_stop(); sda_m = 0; waith(); scl_m = 1; waith(); sda_m = 1; waith(); endtask
  task automatic put_bit(input logic b); sda_m = b; waith(); scl_m = 1; waith(); scl_m = 0; endtask
  task automatic get_bit(output logic b);
    sda_m = 1; waith(); scl_m = 1; repeat (H/2) @(negedge clk); b = sda_line;
    repeat (H/2) @(negedge clk); scl_m = 0;
  endtask
  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a); ack = ~a;
  endtask
  task automatic recv_byte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~mack);
  endtask
  task automatic regs_check(input string req);
    check(req, {r_en, r_vs, r_dc}, {exp_r[0], exp_r[1], exp_r[2]});
  endtask
  task automatic do_write(input logic [7:0] sub, input logic [7:0] val, output logic [2:0] acks);
    logic a0, a1, a2;
    b_start(); send_byte({ADR, 1'b0}, a0); send_byte(sub, a1); send_byte(val, a2); b_stop();
    acks = {a0, a1, a2};
  endtask
  task automatic do_read(output logic [15:0] w, output logic ack);
    b_start(); send_byte({ADR, 1'b1}, ack); recv_byte(w[15:8], 1'b1); recv_byte(w[7:0], 1'b0); b_stop();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic a, ack;
    logic [15:0] w;
    logic [7:0] b1, b2;
    int s0;
    for (int i = 0; i < 3; i++) exp_r[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1 reset state
    regs_check("R1 regs");
    check("R1 oe", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R2 R4 write sweep over defined sub-addresses
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 3; s++) begin
        logic [7:0] v = 8'((s * 8'h47) + (k * 8'h35) + 8'h1B);
        s0 = strobes;
        do_write(8'(s), v, acks);
        exp_r[s] = v;
        check("R2 addr ack", acks[2], 1);
        check("R4 sub/data ack", acks[1:0], 2'b11);
        regs_check("R4 value");
        check("R4 strobe count", strobes - s0, 1);
      end
    end

    // R6 undefined sub-addresses
    for (int s = 3; s < 11; s++) begin
      s0 = strobes;
      do_write((s == 10) ? 8'hFF : 8'(s), 8'h5A, acks);
      check("R6 data ack", acks, 3'b111);
      check("R6 no strobe", strobes - s0, 0);
      regs_check("R6 unchanged");
    end

    // R5 second data byte refused
    b_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h02, a); send_byte(8'hC3, a);
    check("R5 first ack", a, 1);
    send_byte(8'h7E, a); b_stop();
    exp_r[2] = 8'hC3;
    check("R5 second nack", a, 0);
    regs_check("R5 regs");

    // R3 address mismatch
    for (int m = 0; m < 3; m++) begin
      logic [6:0] bad_adr = (m == 0) ? 7'h09 : (m == 1) ? 7'h48 : 7'h00;
      b_start(); oe_seen = 0;
      send_byte({bad_adr, 1'b0}, a);
      check("R3 nack", a, 0);
      send_byte(8'h00, a); send_byte(8'hAA, a);
      check("R3 oe never", oe_seen, 0);
      b_stop();
      regs_check("R3 regs");
    end

    // R9 STOP mid data byte
    b_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h00, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    b_stop();
    regs_check("R9 stop abort");
    // R9 repeated START mid data byte, then new write accepted
    b_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h01, a);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    b_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h01, a); send_byte(8'hB6, a); b_stop();
    exp_r[1] = 8'hB6;
    check("R9 restart ack", a, 1);
    regs_check("R9 restart regs");

    // R7 read sweep over all flag values
    for (int f = 0; f < 64; f++) begin
      if (f % 16 == 0) begin
        do_write(8'h01, 8'(f * 4 + 8'h93), acks);
        exp_r[1] = 8'(f * 4 + 8'h93);
      end
      flags = 6'(f); v6 = ^6'(f);
      do_read(w, ack);
      check("R7 addr ack", ack, 1);
      check("R7 word", w, {exp_r[1][7:1], v6, flags, 2'b00});
    end

    // R8 snapshot at address ack
    flags = 6'b101101; v6 = 1;
    b_start(); send_byte({ADR, 1'b1}, a);
    flags = 6'b010010; v6 = 0;
    recv_byte(b1, 1'b1); recv_byte(b2, 1'b0); b_stop();
    check("R8 snapshot", {b1, b2}, {exp_r[1][7:1], 1'b1, 6'b101101, 2'b00});

    // R10 controller NACK after first byte
    flags = 6'b000000; v6 = 0;
    b_start(); send_byte({ADR, 1'b1}, a); recv_byte(b1, 1'b0);
    oe_seen = 0;
    recv_byte(b2, 1'b0); b_stop();
    check("R10 first byte", b1, {exp_r[1][7:1], 1'b0});
    check("R10 released", {b2, 7'b0, oe_seen}, {8'hFF, 8'h00});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule